// File: doc/BRIEF.md
# AC97 Link Frame Controller

This block is the controller end of an AC97 serial audio link. It runs entirely from the bit clock and produces a fixed 256-bit frame. The frame starts with a 16-bit tag slot and continues with twelve 20-bit data slots. The block drives the frame sync pin in every configuration. On each bit clock it shifts one frame bit out on the serial output and captures the matching bit of the codec's frame from the serial input.

Transmit words are pulled one slot at a time. At each slot boundary, `tx_ready` pulses and `tx_slot` names the slot about to be sent. If `tx_valid` is high on that edge, the supplied word is loaded; otherwise the slot is sent as zeros.

Received slots leave the block as words on a valid/ready stream, each tagged with its slot number. This happens only in frames whose tag says the codec is ready. A frame with the codec-ready bit low pushes nothing and sets a sticky status flag, which can also raise an interrupt.

Top module: `ac97_link_ctrl`

## Requirements
- R1: A frame is 256 bit clocks long: a 16-bit tag slot (slot 0) followed by slots 1 to 12 of 20 bits each. Every slot is sent most significant bit first. Output bits change on the rising clock edge. At the rising edge before each slot, `tx_ready` is high, `tx_slot` gives that slot's number, and the word for the slot is taken from `tx_data` if `tx_valid` is high.
- R2: `fsync` is high for exactly the 16 bit clocks of the tag slot and low for the other 240.
- R3: Tag bit 2 is always transmitted as 0. The tag is taken from `tx_data[15:0]`.
- R4: With `mode_20b`=1, a data slot is sent as `tx_data[19:0]`. With `mode_20b`=0, it is sent as `tx_data[15:0]` followed by four zero bits.
- R5: A slot whose word is not valid at its `tx_ready` edge is sent as 20 (or 16 for the tag) zero bits.
- R6: The serial input is sampled on the falling clock edge. After each received slot, one word is presented on `rx_valid`/`rx_data`/`rx_slot`, and it stays valid until `rx_ready` is high on a rising edge. The tag is given as `{4'b0, tag}`. A data slot is given whole in 20-bit mode. In 16-bit mode, it is given as `{4'b0, slot[19:4]}`, so the low four received bits are discarded.
- R7: The codec-ready indication is received tag bit 15, the first bit of the frame. When it is 0, none of that frame's 13 slots is presented on the receive stream.
- R8: `cnr_flag` is set when a received tag has bit 15 low and stays set until `cnr_clr` is high on a rising edge. A new set on the same edge takes priority over the clear.
- R9: `irq` is high exactly when `cnr_flag` is 1 and `cnr_ie` is 1.
- R10: While reset is asserted, `fsync`, `sdout`, `rx_valid`, `cnr_flag` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_20b | input | 1 | 1 selects 20-bit audio words, 0 selects 16-bit |
| tx_valid | input | 1 | Transmit word offered for the requested slot |
| tx_data | input | 20 | Transmit word (tag in bits 15:0) |
| tx_ready | output | 1 | The requested slot is loaded on this edge |
| tx_slot | output | 4 | Number of the slot being requested |
| sdout | output | 1 | Serial data to the codec |
| fsync | output | 1 | Frame sync to the codec |
| sdin | input | 1 | Serial data from the codec |
| rx_valid | output | 1 | Received word available |
| rx_data | output | 20 | Received word |
| rx_slot | output | 4 | Slot number of the received word |
| rx_ready | input | 1 | Consumer takes the received word |
| cnr_ie | input | 1 | Interrupt enable for codec-not-ready |
| cnr_clr | input | 1 | Write-one-to-clear for the codec-not-ready flag |
| cnr_flag | output | 1 | Sticky codec-not-ready flag |
| irq | output | 1 | Codec-not-ready interrupt |

## Verification
Several properties are checked on every cycle:
- the frame sync edges around the tag slot;
- a zero on the line while tag bit 2 is being sent;
- zero output after a slot that had no valid word;
- no receive word presented while the codec is not ready;
- the set and clear behaviour of the sticky flag.

Only the bench scenarios can show the actual bit order and slot layout of a whole frame. The same holds for packing of 16-bit and 20-bit words in both directions, the exact sequence of received words with their slot numbers, and the interrupt gating.

// File: rtl/ac97_link_pkg.sv
package ac97_link_pkg;
    localparam int TAG_BITS      = 16;
    localparam int SLOT_BITS     = 20;
    localparam int SMALL_BITS    = 16;
    localparam int NUM_SLOTS     = 13;
    localparam int RSVD_TAG_BIT  = 2;
    localparam int READY_TAG_BIT = TAG_BITS - 1;
    localparam int SLOT_IDX_W    = $clog2(NUM_SLOTS);
    localparam int BIT_IDX_W     = $clog2(SLOT_BITS);
    localparam int PAD_BITS      = SLOT_BITS - SMALL_BITS;
    localparam int TAG_PAD       = SLOT_BITS - TAG_BITS;
    localparam int FRAME_BITS    = TAG_BITS + (NUM_SLOTS - 1) * SLOT_BITS;

    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
    typedef logic [BIT_IDX_W-1:0]  bit_idx_t;
    typedef logic [SLOT_BITS-1:0]  slot_word_t;

    typedef struct packed {
        slot_idx_t slot;
        bit_idx_t  bitc;
    } timer_st_t;

    typedef struct packed {
        slot_word_t sh;
    } tx_st_t;

    typedef struct packed {
        slot_word_t sh;
        logic       rdy;
        logic       vld;
        slot_word_t data;
        slot_idx_t  slot;
        logic       flag;
    } rx_st_t;
endpackage

// File: rtl/ac97_slot_timer.sv
module ac97_slot_timer
    import ac97_link_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    output slot_idx_t slot_o,
    output bit_idx_t  bitc_o,
    output logic      last_o,
    output slot_idx_t next_slot_o,
    output logic      fsync_o
);
    localparam slot_idx_t LAST_SLOT = slot_idx_t'(NUM_SLOTS - 1);

    timer_st_t st_d, st_q;
    logic      last_w;
    slot_idx_t next_w;

    always_comb begin
        st_d   = st_q;
        last_w = (st_q.bitc == '0);
        next_w = (st_q.slot == LAST_SLOT) ? '0 : slot_idx_t'(st_q.slot + 1'b1);
        if (last_w) begin
            st_d.slot = next_w;
            st_d.bitc = (next_w == '0) ? bit_idx_t'(TAG_BITS - 1)
                                       : bit_idx_t'(SLOT_BITS - 1);
        end else begin
            st_d.bitc = bit_idx_t'(st_q.bitc - 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= LAST_SLOT;
            st_q.bitc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o      = st_q.slot;
    assign bitc_o      = st_q.bitc;
    assign last_o      = last_w;
    assign next_slot_o = next_w;
    assign fsync_o     = (st_q.slot == '0);

    // R2
    fs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_w && st_q.slot == '0) |=> !fsync_o);
    // R2
    fs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_w && st_q.slot == LAST_SLOT) |=> fsync_o);
endmodule

// File: rtl/ac97_tx_path.sv
module ac97_tx_path
    import ac97_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_20b_i,
    input  logic       load_i,
    input  slot_idx_t  next_slot_i,
    input  logic       tx_valid_i,
    input  slot_word_t tx_data_i,
    output logic       sdo_o
);
    tx_st_t              st_d, st_q;
    logic [TAG_BITS-1:0] tag_w;
    slot_word_t          word_w;

    always_comb begin
        tag_w               = tx_data_i[TAG_BITS-1:0];
        tag_w[RSVD_TAG_BIT] = 1'b0;
        word_w = mode_20b_i ? tx_data_i
                            : {tx_data_i[SMALL_BITS-1:0], {PAD_BITS{1'b0}}};
        st_d.sh = {st_q.sh[SLOT_BITS-2:0], 1'b0};
        if (load_i) begin
            if (!tx_valid_i)
                st_d.sh = '0;
            else if (next_slot_i == '0)
                st_d.sh = {tag_w, {TAG_PAD{1'b0}}};
            else
                st_d.sh = word_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_o = st_q.sh[SLOT_BITS-1];

    // R5
    empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !tx_valid_i) |=> !sdo_o);
endmodule

// File: rtl/ac97_rx_path.sv
module ac97_rx_path
    import ac97_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_20b_i,
    input  logic       sdin_i,
    input  logic       done_i,
    input  slot_idx_t  cur_slot_i,
    input  logic       rx_ready_i,
    input  logic       cnr_clr_i,
    output logic       rx_valid_o,
    output slot_word_t rx_data_o,
    output slot_idx_t  rx_slot_o,
    output logic       cnr_flag_o
);
    rx_st_t              st_d, st_q;
    logic                smp_q;
    logic [TAG_BITS-1:0] tag_w;
    logic                tag_done_w;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= 1'b0;
        else        smp_q <= sdin_i;
    end

    always_comb begin
        st_d       = st_q;
        st_d.sh    = {st_q.sh[SLOT_BITS-2:0], smp_q};
        tag_w      = st_d.sh[TAG_BITS-1:0];
        tag_done_w = done_i && (cur_slot_i == '0);
        if (rx_ready_i) st_d.vld  = 1'b0;
        if (cnr_clr_i)  st_d.flag = 1'b0;
        if (tag_done_w) begin
            st_d.rdy = tag_w[READY_TAG_BIT];
            if (!tag_w[READY_TAG_BIT]) begin
                st_d.flag = 1'b1;
            end else begin
                st_d.vld  = 1'b1;
                st_d.slot = '0;
                st_d.data = {{TAG_PAD{1'b0}}, tag_w};
            end
        end else if (done_i && st_q.rdy) begin
            st_d.vld  = 1'b1;
            st_d.slot = cur_slot_i;
            st_d.data = mode_20b_i ? st_d.sh
                                   : {{PAD_BITS{1'b0}}, st_d.sh[SLOT_BITS-1 -: SMALL_BITS]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_valid_o = st_q.vld;
    assign rx_data_o  = st_q.data;
    assign rx_slot_o  = st_q.slot;
    assign cnr_flag_o = st_q.flag;

    // R7
    muted_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cur_slot_i != '0 && !st_q.rdy && !rx_valid_o) |=> !rx_valid_o);
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_done_w && !tag_w[READY_TAG_BIT]) |=> cnr_flag_o);
    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnr_clr_i && !tag_done_w) |=> !cnr_flag_o);
endmodule

// File: rtl/ac97_link_ctrl.sv
module ac97_link_ctrl
    import ac97_link_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_20b,
    input  logic        tx_valid,
    input  logic [19:0] tx_data,
    output logic        tx_ready,
    output logic [3:0]  tx_slot,
    output logic        sdout,
    output logic        fsync,
    input  logic        sdin,
    output logic        rx_valid,
    output logic [19:0] rx_data,
    output logic [3:0]  rx_slot,
    input  logic        rx_ready,
    input  logic        cnr_ie,
    input  logic        cnr_clr,
    output logic        cnr_flag,
    output logic        irq
);
    slot_idx_t cur_slot, next_slot;
    bit_idx_t  cur_bit;
    logic      slot_last;

    ac97_slot_timer i_timer (
        .clk(clk), .rst_n(rst_n),
        .slot_o(cur_slot), .bitc_o(cur_bit), .last_o(slot_last),
        .next_slot_o(next_slot), .fsync_o(fsync)
    );

    ac97_tx_path i_tx (
        .clk(clk), .rst_n(rst_n), .mode_20b_i(mode_20b),
        .load_i(slot_last), .next_slot_i(next_slot),
        .tx_valid_i(tx_valid), .tx_data_i(tx_data), .sdo_o(sdout)
    );

    ac97_rx_path i_rx (
        .clk(clk), .rst_n(rst_n), .mode_20b_i(mode_20b), .sdin_i(sdin),
        .done_i(slot_last), .cur_slot_i(cur_slot), .rx_ready_i(rx_ready),
        .cnr_clr_i(cnr_clr), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .rx_slot_o(rx_slot), .cnr_flag_o(cnr_flag)
    );

    assign tx_ready = slot_last;
    assign tx_slot  = next_slot;
    assign irq      = cnr_flag & cnr_ie;

    // R3
    rsvd_tag_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_slot == '0 && cur_bit == bit_idx_t'(RSVD_TAG_BIT)) |-> !sdout);
endmodule

// File: tb/test_ac97_link_ctrl.sv
module test_ac97_link_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_20b = 1'b1;
    logic        tx_valid = 1'b0;
    logic [19:0] tx_data = '0;
    logic        tx_ready;
    logic [3:0]  tx_slot;
    logic        sdout, fsync;
    logic        sdin = 1'b0;
    logic        rx_valid;
    logic [19:0] rx_data;
    logic [3:0]  rx_slot;
    logic        rx_ready = 1'b1;
    logic        cnr_ie = 1'b0;
    logic        cnr_clr = 1'b0;
    logic        cnr_flag, irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [19:0] txw [13];
    logic        txv [13];
    logic [19:0] rxw [13];
    logic [3:0]  gslot [16];
    logic [19:0] gdata [16];
    int          got;

    always #4 clk = ~clk;

    ac97_link_ctrl i_ac97_link_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_20b(mode_20b),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_slot(tx_slot),
        .sdout(sdout), .fsync(fsync), .sdin(sdin),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_slot(rx_slot), .rx_ready(rx_ready),
        .cnr_ie(cnr_ie), .cnr_clr(cnr_clr), .cnr_flag(cnr_flag), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic rx_bit(input int pos);
        int s, b;
        if (pos < 16) return rxw[0][15-pos];
        s = (pos - 16) / 20 + 1;
        b = 19 - ((pos - 16) % 20);
        return rxw[s][b];
    endfunction

    function automatic logic tx_bit(input int pos);
        int s, b;
        logic [15:0] tag;
        logic [19:0] w;
        if (pos < 16) begin
            if (!txv[0]) return 1'b0;
            tag = txw[0][15:0];
            tag[2] = 1'b0;
            return tag[15-pos];
        end
        s = (pos - 16) / 20 + 1;
        b = 19 - ((pos - 16) % 20);
        if (!txv[s]) return 1'b0;
        w = mode_20b ? txw[s] : {txw[s][15:0], 4'h0};
        return w[b];
    endfunction

    // One full frame from a fresh reset; checks serial output, sync shape,
    // received words and the flag.
    task automatic run_frame(input string req);
        int bad_sd, bad_fs, first_bad;
        int nexp;
        logic [19:0] e;
        bad_sd = 0; bad_fs = 0; first_bad = -1; got = 0;
        rst_n = 1'b0; sdin = 1'b0; tx_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 258; cyc++) begin
            if (tx_ready) begin
                tx_valid = txv[tx_slot];
                tx_data  = txw[tx_slot];
            end else begin
                tx_valid = 1'b0;
                tx_data  = '0;
            end
            if (cyc >= 1 && cyc <= 256) begin
                if (sdout !== tx_bit(cyc - 1)) begin
                    bad_sd++;
                    if (first_bad < 0) first_bad = cyc - 1;
                end
                if (fsync !== ((cyc - 1) < 16)) bad_fs++;
            end
            if (rx_valid === 1'b1 && got < 16) begin
                gslot[got] = rx_slot;
                gdata[got] = rx_data;
                got++;
            end
            @(posedge clk);
            #1;
            sdin = (cyc < 256) ? rx_bit(cyc) : 1'b0;
            @(negedge clk);
        end
        tx_valid = 1'b0;
        sdin = 1'b0;
        chk({req, " R1 R3 R4 R5"}, $sformatf("sdout bit errors (first at %0d)", first_bad), bad_sd, 0);
        chk("R2", "fsync shape errors", bad_fs, 0);
        nexp = rxw[0][15] ? 13 : 0;
        chk("R7", "received word count", got, nexp);
        for (int i = 0; i < nexp && i < got; i++) begin
            if (i == 0) e = {4'h0, rxw[0][15:0]};
            else        e = mode_20b ? rxw[i] : {4'h0, rxw[i][19:4]};
            chk("R6", $sformatf("rx slot number %0d", i), gslot[i], i);
            chk("R6", $sformatf("rx word %0d", i), gdata[i], e);
        end
        chk("R8", "sticky flag after frame", cnr_flag, !rxw[0][15]);
        chk("R9", "irq after frame", irq, cnr_flag & cnr_ie);
    endtask

    task automatic fill(input logic m20, input logic [15:0] ttag, input logic [15:0] rtag);
        mode_20b = m20;
        txw[0] = {4'h0, ttag};
        rxw[0] = {4'h0, rtag};
        txv[0] = 1'b1;
        for (int s = 1; s < 13; s++) begin
            txw[s] = 20'h5A3C1 ^ (20'(s) * 20'h0F1E3);
            rxw[s] = 20'hC3A5F ^ (20'(s) * 20'h1B2D7);
            txv[s] = 1'b1;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cnr_ie = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "fsync in reset", fsync, 0);
        chk("R10", "sdout in reset", sdout, 0);
        chk("R10", "rx_valid in reset", rx_valid, 0);
        chk("R10", "cnr_flag in reset", cnr_flag, 0);
        chk("R10", "irq in reset", irq, 0);
    endtask

    task automatic t_ready_20();
        cnr_ie = 1'b1;
        fill(1'b1, 16'hFFFF, 16'hFFFC);
        run_frame("R1 20-bit");
    endtask

    task automatic t_ready_16();
        cnr_ie = 1'b1;
        fill(1'b0, 16'hB7A5, 16'h9FF8);
        run_frame("R4 16-bit");
    endtask

    task automatic t_gaps();
        fill(1'b1, 16'h8004, 16'h8000);
        txv[0] = 1'b0; txv[3] = 1'b0; txv[12] = 1'b0;
        run_frame("R5 missing words");
    endtask

    task automatic t_not_ready();
        cnr_ie = 1'b1;
        fill(1'b1, 16'hF00D, 16'h7FF8);
        run_frame("R7 not ready");
        chk("R9", "irq raised with enable", irq, 1);
        cnr_ie = 1'b0;
        #1;
        chk("R9", "irq masked by enable", irq, 0);
        chk("R8", "flag kept while masked", cnr_flag, 1);
        cnr_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cnr_clr = 1'b0;
        chk("R8", "flag after clear", cnr_flag, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ready_20();
        t_ready_16();
        t_gaps();
        t_not_ready();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule